// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an external active-low reset button is held. The button input is asynchronous. It is synchronized and then gates a counter that advances once per cycle of the 25 MHz reference clock. The counter saturates at its top value instead of wrapping. The count is not lost when the button is released; it is kept until software clears it. This lets firmware read the hold time after the system comes back up and decide whether a factory reset was requested.

A small register interface gives access to two registers. The length register at select 0 returns the count and clears the count when bit 31 is written as one. The delay register at select 1 holds a whole number of seconds. When the button is released, the block compares the count against the delay times the ticks per second (25,000,000 by default). If the count has reached that value, it raises a sticky factory-reset request.

Top module: `rst_hold_meter`

## Requirements
- R1: While the button input is low, the count increases by exactly one on each clock edge at which the synchronized input is low. The input passes through a two-flop synchronizer, so a hold that is sampled low on N clock edges yields a count of N.
- R2: After release, the count stays unchanged. A later hold continues from the kept value unless the count has been cleared in between.
- R3: The count saturates at 2^CNT_W-1 (29 bits by default) and never wraps.
- R4: A read with select 0 returns the count in bits CNT_W-1:0. All higher bits, including 30:29 and 31, read as zero.
- R5: A write with select 0 and bit 31 set clears both the count and the factory-reset request to zero. A write with select 0 and bit 31 clear has no effect.
- R6: A write with select 1 stores bits DLY_W-1:0 of the write data as the delay in seconds. A read with select 1 returns that value, zero-extended.
- R7: On release, the factory-reset request sets if the count is greater than or equal to delay × TICKS. It stays clear if the count is one below that value.
- R8: The factory-reset request never sets while the button is still held. Once set, it stays set through later holds until a clear.
- R9: A delay of zero keeps the factory-reset request clear, whatever the count.
- R10: The synchronous active-high reset clears the count, the delay, the read data and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_rst_n | input | 1 | Asynchronous active-low reset button |
| bus_sel | input | 1 | Register select: 0 length, 1 delay |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the selected register |
| factory_req | output | 1 | Sticky factory-reset request |

## Verification
A wrong count is visible at the length register on the read that follows. The read data is registered, so it appears one cycle after the select is set. The synchronizer latency fixes exactly how many cycles a hold contributes. A count that is off by one therefore shows as a direct value mismatch after any hold. A bad saturation or wrap only shows once the count passes the top value, so the bench uses a narrow counter to reach it. A wrong threshold or a wrong release detector shows on the request output. The request settles within three cycles after the input rises. The bench probes the exact boundary (count one below the threshold, then equal to it). It also checks the request while the button is still held past the threshold.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
  localparam int BUS_W   = 32;
  localparam int CLR_POS = 31;

  typedef enum logic {
    SEL_LEN = 1'b0,
    SEL_DLY = 1'b1
  } rhm_sel_e;
endpackage

// File: rtl/rhm_sync.sv
module rhm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rhm_counter.sv
module rhm_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                 cnt_q <= '0;
    else if (hold && !sat)          cnt_q <= cnt_q + 1'b1;
  end

  assign sat   = (cnt_q == CNT_MAX);
  assign count = cnt_q;
endmodule

// File: rtl/rhm_thresh.sv
module rhm_thresh #(
  parameter int CNT_W = 29,
  parameter int DLY_W = 8,
  parameter int TICKS = 25000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clr,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_wdata,
  input  logic [CNT_W-1:0] count,
  output logic [DLY_W-1:0] dly_q,
  output logic             flag
);
  localparam int TICK_W = $clog2(TICKS + 1);
  localparam int THR_W  = DLY_W + TICK_W;
  localparam int CMP_W  = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [THR_W-1:0] thr_q;
  logic             thr_en;
  logic             hold_q;
  logic             release_evt;
  logic             reached;

  always_ff @(posedge clk) begin
    if (rst)         dly_q <= '0;
    else if (dly_we) dly_q <= dly_wdata;
  end

  // threshold pipelined one stage behind the delay register
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      thr_en <= 1'b0;
    end else begin
      thr_q  <= THR_W'(dly_q) * THR_W'(TICKS);
      thr_en <= (dly_q != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold;
  end

  assign release_evt = hold_q && !hold;
  assign reached     = CMP_W'(count) >= CMP_W'(thr_q);

  always_ff @(posedge clk) begin
    if (rst || clr)                           flag <= 1'b0;
    else if (release_evt && thr_en && reached) flag <= 1'b1;
  end
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rhm_pkg::*;
#(
  parameter int CNT_W   = 29,
  parameter int DLY_W   = 8,
  parameter int TICKS   = 25000000,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             factory_req
);
  logic             btn_sync;
  logic             btn_held;
  logic             len_clr;
  logic             dly_we;
  logic             cnt_sat;
  logic [CNT_W-1:0] hold_cnt;
  logic [DLY_W-1:0] dly_val;
  rhm_sel_e         sel;

  assign sel = rhm_sel_e'(bus_sel);

  rhm_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(btn_rst_n),
    .sync_out(btn_sync)
  );

  assign btn_held = !btn_sync;
  assign len_clr  = bus_we && (sel == SEL_LEN) && bus_wdata[CLR_POS];
  assign dly_we   = bus_we && (sel == SEL_DLY);

  rhm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .hold (btn_held),
    .clr  (len_clr),
    .count(hold_cnt),
    .sat  (cnt_sat)
  );

  rhm_thresh #(.CNT_W(CNT_W), .DLY_W(DLY_W), .TICKS(TICKS)) u_thr (
    .clk      (clk),
    .rst      (rst),
    .hold     (btn_held),
    .clr      (len_clr),
    .dly_we   (dly_we),
    .dly_wdata(bus_wdata[DLY_W-1:0]),
    .count    (hold_cnt),
    .dly_q    (dly_val),
    .flag     (factory_req)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (sel)
        SEL_LEN: bus_rdata <= BUS_W'(hold_cnt);
        SEL_DLY: bus_rdata <= BUS_W'(dly_val);
        default: bus_rdata <= '0;
      endcase
    end
  end

  logic unused_sat;
  assign unused_sat = cnt_sat;
endmodule

// File: rtl/rhm_chk.sv
module rhm_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic [31:0]      rdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr && count != CNT_MAX) |=> count == CNT_W'($past(count) + 1'b1));

  // R2
  count_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !clr) |=> $stable(count));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);

  // R4
  len_pad_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[30:29] == 2'b00);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && !flag));

  // R8
  no_set_while_held_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !flag) |=> !flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

bind rst_hold_meter rhm_chk #(.CNT_W(CNT_W)) u_rhm_chk (
  .clk  (clk),
  .rst  (rst),
  .hold (btn_held),
  .clr  (len_clr),
  .count(hold_cnt),
  .flag (factory_req),
  .rdata(bus_rdata)
);

// File: tb/rst_hold_meter_test.sv
module rst_hold_meter_test;
  localparam int CNT_W = 10;
  localparam int DLY_W = 8;
  localparam int TICKS = 50;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn_rst_n = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        factory_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rst_hold_meter #(.CNT_W(CNT_W), .DLY_W(DLY_W), .TICKS(TICKS)) uut (
    .clk        (clk),
    .rst        (rst),
    .btn_rst_n  (btn_rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .factory_req(factory_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] val);
    @(negedge clk);
    bus_sel = sel;
    @(negedge clk);
    val = bus_rdata;
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge clk);
    bus_sel = sel; bus_we = 1'b1; bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic hold_btn(input int n);
    @(negedge clk);
    btn_rst_n = 1'b0;
    repeat (n) @(negedge clk);
    btn_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R10 length after reset", v, 0);
    rd(1'b1, v); chk("R10 delay after reset", v, 0);
    chk("R10 request after reset", {31'b0, factory_req}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    hold_btn(37);
    rd(1'b0, v); chk("R1 count after 37 cycles", v, 37);
  endtask

  task automatic t_accum();
    logic [31:0] v;
    repeat (10) @(negedge clk);
    rd(1'b0, v); chk("R2 count kept after release", v, 37);
    hold_btn(20);
    rd(1'b0, v); chk("R2 count continues", v, 57);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(1'b0, 32'h7FFF_FFFF);
    rd(1'b0, v); chk("R5 write without bit 31 ignored", v, 57);
    wr(1'b0, 32'h8000_0000);
    rd(1'b0, v); chk("R5 bit 31 clears count", v, 0);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    hold_btn(MAXC + 80);
    rd(1'b0, v); chk("R3 saturated count", v, MAXC);
    chk("R4 upper bits zero", {v[31:CNT_W]}, 0);
    wr(1'b0, 32'h8000_0000);
  endtask

  task automatic t_dly();
    logic [31:0] v;
    wr(1'b1, 32'h0000_0302);
    rd(1'b1, v); chk("R6 delay readback", v, 32'h02);
  endtask

  task automatic t_thr();
    logic [31:0] v;
    hold_btn(2 * TICKS - 1);
    chk("R7 below threshold", {31'b0, factory_req}, 0);
    wr(1'b0, 32'h8000_0000);
    hold_btn(2 * TICKS);
    chk("R7 at threshold", {31'b0, factory_req}, 1);
    rd(1'b0, v); chk("R1 count at threshold", v, 2 * TICKS);
  endtask

  task automatic t_sticky();
    wr(1'b0, 32'h8000_0000);
    chk("R5 clear drops request", {31'b0, factory_req}, 0);
    @(negedge clk);
    btn_rst_n = 1'b0;
    repeat (2 * TICKS + 10) @(negedge clk);
    chk("R8 no request while held", {31'b0, factory_req}, 0);
    btn_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 request on release", {31'b0, factory_req}, 1);
    hold_btn(5);
    chk("R8 request sticky", {31'b0, factory_req}, 1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h8000_0000);
    hold_btn(4 * TICKS);
    chk("R9 zero delay no request", {31'b0, factory_req}, 0);
    rd(1'b0, v); chk("R1 count with zero delay", v, 4 * TICKS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_accum();
    t_clear();
    t_sat();
    t_dly();
    t_thr();
    t_sticky();
    t_zero();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule